// File: doc/BRIEF.md
# Boundary-Scan Pin Register Chain

This block is the serial register that sits between a test access port controller and the device pins. It lets a tester watch the pins and, under test instructions, drive them. Every input pin owns one cell. Every output pin owns two cells: one for the value it drives and one for its high-impedance enable. All cells are strung into one shift path from `tdi` to `tdo`. The TAP controller supplies the capture, shift and update strobes, and a two-bit instruction class tells the block which test mode applies.

In the observe/preload class the chain captures, shifts and loads its update latches, while the core keeps driving the pads. In the external-test class the update latches drive the pads. In the clamp class the latches keep driving the pads, but the chain is frozen, because the TAP's bypass register carries the serial data in that class. In the functional class the chain is idle and the core drives the pads. The pad value and enable are registered, so they follow their source one clock later.

Top module: `bscan_chain`

## Requirements
- R1: Under synchronous active-high reset, all chain cells and `tdo` go to 0, the update latches go to data 0 with the enable at 1 (high-Z), and `pad_out`=0, `pad_hiz`=all ones.
- R2: The chain is N_IN+2*N_OUT cells long. `tdo` is cell 0. When `mode` is 1 or 2 and `shift_dr` is high, each clock moves every cell one place toward `tdo` and loads `tdi` into the top cell.
- R3: Cell ordering is fixed. Cells 0..N_IN-1 belong to `pin_in[i]`. Output k uses cell N_IN+2k for its high-Z enable and cell N_IN+2k+1, the one nearer `tdi`, for its data.
- R4: On a `capture_dr` clock with `mode` 1 or 2, input cells load `pin_in`, data cells load `pad_out` and enable cells load `pad_hiz`, all as they were before that clock edge.
- R5: The update latches load the data and enable cells on an `update_dr` clock only when `mode` is 1 (observe/preload) or 2 (external test).
- R6: When `mode` is 2 or 3 (clamp), `pad_out`/`pad_hiz` equal the update latches one clock later. When `mode` is 0 (functional) or 1, they equal `core_out`/`core_hiz` one clock later.
- R7: With `mode` 0 or 3, `capture_dr`, `shift_dr` and `update_dr` have no effect on the chain, on `tdo` or on the latches.
- R8: The pad values do not change while the chain shifts in mode 2. Only an update changes them.
- R9: If `capture_dr` and `shift_dr` are both high in the same clock, the capture happens and the shift does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Instruction class: 0 functional, 1 observe/preload, 2 external test, 3 clamp |
| capture_dr | input | 1 | Capture strobe from TAP |
| shift_dr | input | 1 | Shift strobe from TAP |
| update_dr | input | 1 | Update strobe from TAP |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (cell 0) |
| pin_in | input | N_IN | Input pin values observed |
| core_out | input | N_OUT | Core output data |
| core_hiz | input | N_OUT | Core high-Z enable (1 = high-Z) |
| pad_out | output | N_OUT | Registered pad data |
| pad_hiz | output | N_OUT | Registered pad high-Z enable |

## Verification
A capture can land on the same clock as a change of the pad register, because the pads keep following the core during observe/preload. The bench changes `core_out` and `core_hiz` on the very cycle it raises `capture_dr`. It then expects the shifted-out data and enable bits to be the pad values from before that edge, not the new core values. A behavioural queue model, clocked alongside the design, supplies the expected `tdo` and pad values on every cycle.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [1:0] {
    BS_FUNC    = 2'd0,
    BS_PRELOAD = 2'd1,
    BS_DRIVE   = 2'd2,
    BS_HOLD    = 2'd3
  } bs_mode_e;

  function automatic int chain_len(int ni, int no);
    return ni + 2 * no;
  endfunction

  // enable cell of output k sits below (nearer tdo) its data cell
  function automatic int hiz_pos(int ni, int k);
    return ni + 2 * k;
  endfunction

  function automatic int data_pos(int ni, int k);
    return ni + 2 * k + 1;
  endfunction
endpackage

// File: rtl/bscan_cells.sv
module bscan_cells import bscan_pkg::*; #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3,
  localparam int LEN  = chain_len(N_IN, N_OUT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_en,
  input  logic             sh_en,
  input  logic             tdi,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] obs_out,
  input  logic [N_OUT-1:0] obs_hiz,
  output logic [LEN-1:0]   cells,
  output logic             tdo
);
  logic [LEN-1:0] snap;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    assign snap[i] = pin_in[i];
  end
  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    assign snap[hiz_pos(N_IN, k)]  = obs_hiz[k];
    assign snap[data_pos(N_IN, k)] = obs_out[k];
  end

  always_ff @(posedge clk) begin
    if (rst)         cells <= '0;
    else if (cap_en) cells <= snap;
    else if (sh_en)  cells <= {tdi, cells[LEN-1:1]};
  end

  assign tdo = cells[0];

  a_r4_capture_inputs: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> cells[N_IN-1:0] == $past(pin_in));
  a_r2_shift_step: assert property (@(posedge clk) disable iff (rst)
    (sh_en && !cap_en) |=> (cells[LEN-2:0] == $past(cells[LEN-1:1])) && (cells[LEN-1] == $past(tdi)));
endmodule

// File: rtl/bscan_latch.sv
module bscan_latch import bscan_pkg::*; #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3,
  localparam int LEN  = chain_len(N_IN, N_OUT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic [LEN-1:0]   cells,
  output logic [N_OUT-1:0] lat_out,
  output logic [N_OUT-1:0] lat_hiz
);
  logic [N_OUT-1:0] pick_out, pick_hiz;

  always_comb begin
    for (int k = 0; k < N_OUT; k++) begin
      pick_out[k] = cells[data_pos(N_IN, k)];
      pick_hiz[k] = cells[hiz_pos(N_IN, k)];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_out <= '0;
      lat_hiz <= '1;
    end else if (upd_en) begin
      lat_out <= pick_out;
      lat_hiz <= pick_hiz;
    end
  end

  a_r8_latch_quiet: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(lat_out) && $stable(lat_hiz));
endmodule

// File: rtl/bscan_pad.sv
module bscan_pad #(
  parameter int N_OUT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             drive_sel,
  input  logic [N_OUT-1:0] lat_out,
  input  logic [N_OUT-1:0] lat_hiz,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_hiz,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OUT-1:0] pad_hiz
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_hiz <= '1;
    end else if (drive_sel) begin
      pad_out <= lat_out;
      pad_hiz <= lat_hiz;
    end else begin
      pad_out <= core_out;
      pad_hiz <= core_hiz;
    end
  end
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain import bscan_pkg::*; #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             tdi,
  output logic             tdo,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_hiz,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OUT-1:0] pad_hiz
);
  localparam int LEN = chain_len(N_IN, N_OUT);

  bs_mode_e         cur;
  logic             chain_sel, drive_sel;
  logic [LEN-1:0]   cells;
  logic [N_OUT-1:0] lat_out, lat_hiz;

  assign cur       = bs_mode_e'(mode);
  assign chain_sel = (cur == BS_PRELOAD) || (cur == BS_DRIVE);
  assign drive_sel = (cur == BS_DRIVE) || (cur == BS_HOLD);

  bscan_cells #(.N_IN(N_IN), .N_OUT(N_OUT)) u_cells (
    .clk(clk), .rst(rst),
    .cap_en(chain_sel && capture_dr),
    .sh_en(chain_sel && shift_dr),
    .tdi(tdi), .pin_in(pin_in),
    .obs_out(pad_out), .obs_hiz(pad_hiz),
    .cells(cells), .tdo(tdo)
  );

  bscan_latch #(.N_IN(N_IN), .N_OUT(N_OUT)) u_latch (
    .clk(clk), .rst(rst),
    .upd_en(chain_sel && update_dr),
    .cells(cells),
    .lat_out(lat_out), .lat_hiz(lat_hiz)
  );

  bscan_pad #(.N_OUT(N_OUT)) u_pad (
    .clk(clk), .rst(rst), .drive_sel(drive_sel),
    .lat_out(lat_out), .lat_hiz(lat_hiz),
    .core_out(core_out), .core_hiz(core_hiz),
    .pad_out(pad_out), .pad_hiz(pad_hiz)
  );

  a_r7_chain_frozen: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 || mode == 2'd3) |=> $stable(cells) && $stable(lat_out) && $stable(lat_hiz));
  a_r6_test_drive: assert property (@(posedge clk) disable iff (rst)
    (mode[1]) |=> pad_out == $past(lat_out) && pad_hiz == $past(lat_hiz));
  a_r6_core_drive: assert property (@(posedge clk) disable iff (rst)
    (!mode[1]) |=> pad_out == $past(core_out) && pad_hiz == $past(core_hiz));
  a_r4_capture_pads: assert property (@(posedge clk) disable iff (rst)
    (chain_sel && capture_dr) |=> cells[data_pos(N_IN, 0)] == $past(pad_out[0])
                                  && cells[hiz_pos(N_IN, 0)] == $past(pad_hiz[0]));
endmodule

// File: tb/sim_bscan_chain.sv
module sim_bscan_chain;
  localparam int NI = 4;
  localparam int NO = 3;
  localparam int L  = NI + 2 * NO;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [NI-1:0] pin_in = '0;
  logic [NO-1:0] core_out = '0, core_hiz = '0;
  logic [NO-1:0] pad_out, pad_hiz;

  int checks = 0, errors = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  bscan_chain #(.N_IN(NI), .N_OUT(NO)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .pin_in(pin_in), .core_out(core_out), .core_hiz(core_hiz),
    .pad_out(pad_out), .pad_hiz(pad_hiz)
  );

  // behavioural reference: queue front is the cell next to tdo
  bit mq[$];
  logic [NO-1:0] mud, muh, mpo, mph, opo, oph;
  bit act, drv;

  always @(posedge clk) begin
    if (rst) begin
      mq = {};
      for (int i = 0; i < L; i++) mq.push_back(1'b0);
      mud = '0; muh = '1; mpo = '0; mph = '1;
    end else begin
      opo = mpo; oph = mph;
      act = (mode == 2'd1) || (mode == 2'd2);
      drv = (mode == 2'd2) || (mode == 2'd3);
      if (drv) begin mpo = mud; mph = muh; end
      else begin mpo = core_out; mph = core_hiz; end
      if (act && update_dr)
        for (int k = 0; k < NO; k++) begin
          mud[k] = mq[NI + 2*k + 1];
          muh[k] = mq[NI + 2*k];
        end
      if (act && capture_dr) begin
        for (int i = 0; i < NI; i++) mq[i] = pin_in[i];
        for (int k = 0; k < NO; k++) begin
          mq[NI + 2*k]     = oph[k];
          mq[NI + 2*k + 1] = opo[k];
        end
      end else if (act && shift_dr) begin
        void'(mq.pop_front());
        mq.push_back(tdi);
      end
    end
  end

  task automatic chk(string r, logic [31:0] a, logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  task automatic step(logic [1:0] m, logic c, logic s, logic u, logic t);
    mode = m; capture_dr = c; shift_dr = s; update_dr = u; tdi = t;
    @(posedge clk); #1;
    chk({tag, " tdo"}, 32'(tdo), 32'(mq[0]));
    chk({tag, " pad_out"}, 32'(pad_out), 32'(mpo));
    chk({tag, " pad_hiz"}, 32'(pad_hiz), 32'(mph));
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [L-1:0] got;
    logic [L-1:0] pat;
    @(negedge clk);
    tag = "R1";
    step(2'd0, 0, 0, 0, 0);
    step(2'd0, 0, 0, 0, 0);
    chk("R1 reset pad_out", 32'(pad_out), 32'd0);
    chk("R1 reset pad_hiz", 32'(pad_hiz), 32'h7);
    chk("R1 reset tdo", 32'(tdo), 32'd0);
    rst = 1'b0;

    // functional mode: pads follow core one clock later (R6)
    tag = "R6 func";
    core_out = 3'b110; core_hiz = 3'b010;
    step(2'd0, 0, 0, 0, 0);
    step(2'd0, 0, 0, 0, 0);
    chk("R6 pad follows core", 32'(pad_out), 32'h6);

    // capture in preload while core changes on the same edge (R3 R4)
    tag = "R4 capture";
    pin_in = 4'b1010;
    core_out = 3'b001; core_hiz = 3'b101;
    step(2'd1, 1, 0, 0, 0);
    got[0] = tdo;
    tag = "R3 R2 shift out";
    for (int j = 1; j < L; j++) begin
      step(2'd1, 0, 1, 0, 0);
      got[j] = tdo;
    end
    // ordering: pins 0..3, then (hiz,data) pairs from old pad 110/010
    chk("R3 R4 captured order", 32'(got), 32'(10'b1011001010));

    // preload a pattern: data 101, enables 000 (R5)
    tag = "R5 preload";
    pat = 10'b1000100000;
    for (int j = 0; j < L; j++) step(2'd1, 0, 1, 0, pat[j]);
    step(2'd1, 0, 0, 1, 0);
    chk("R5 preload keeps core on pads", 32'(pad_out), 32'(core_out));
    tag = "R6 drive";
    step(2'd2, 0, 0, 0, 0);
    chk("R6 extest pad_out", 32'(pad_out), 32'h5);
    chk("R6 extest pad_hiz", 32'(pad_hiz), 32'h0);

    // shifting under extest leaves pads alone (R8)
    tag = "R8 shift stable";
    for (int j = 0; j < L; j++) step(2'd2, 0, 1, 0, j[0]);
    chk("R8 pads stable while shifting", 32'(pad_out), 32'h5);

    // clamp: strobes ignored, pads held from latches (R7)
    tag = "R7 clamp";
    core_out = 3'b010; pin_in = 4'b0101;
    step(2'd3, 0, 1, 0, 1);
    step(2'd3, 1, 0, 0, 0);
    step(2'd3, 0, 0, 1, 0);
    step(2'd3, 0, 0, 0, 0);
    chk("R7 clamp pad_out", 32'(pad_out), 32'h5);
    chk("R7 clamp pad_hiz", 32'(pad_hiz), 32'h0);
    tag = "R7 func idle";
    step(2'd0, 1, 1, 1, 1);

    // capture beats shift (R9)
    tag = "R9 cap over shift";
    pin_in = 4'b0001;
    step(2'd1, 1, 1, 0, 0);
    chk("R9 capture wins", 32'(tdo), 32'd1);
    step(2'd1, 0, 1, 0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule